// File: doc/BRIEF.md
# Programmable Input Deglitch Filter Bank

This block cleans up a bank of digital input lines before they are read. Each line goes through a two-flop synchroniser. A channel whose filter is enabled then takes a new level only after the line has held that level for a programmed number of 200 ns ticks. A channel whose filter is disabled passes its synchronised level straight through.

All channels share one interval value, and each channel has its own enable bit. A byte-wide write port programs the interval, the enable mask and a command register. The command register can load the interval and restart the timer, and it can snap every filter to the present input. Software reads the resulting levels back one byte at a time on the same port.

The prescaler is a parameter (`TICK_DIV` system clocks per tick), so the block can run from any system clock. A freshly written interval does nothing until a restart command loads it. This lets a multi-byte interval be changed without the filters ever seeing a half-written value.

Top module: `deglitch_bank`

## Requirements
- R1: A channel with its enable bit low shows its raw input on the readback port two clock edges after the input changes.
- R2: Reset clears every enable bit, so after reset all channels pass their inputs through.
- R3: A read at address 0, 1 or 2 returns channels 0-7, 8-15 or 16-23, with the lowest channel of each byte in bit 0. Every other address reads as zero.
- R4: The enable mask is written at addresses 8, 9 and 10. Bit b of byte k enables channel 8k+b.
- R5: The staged interval is written at addresses 4 (bits 7:0), 5 (bits 15:8) and 6 (bits 19:16 taken from data bits 3:0). Data bits 7:4 at address 6 are ignored.
- R6: Writing the command register (address 12) with bit 0 set does three things: it loads the staged interval into the active interval, it restarts the tick prescaler and it clears every stable-time counter. Writing the staged interval alone does not change filtering.
- R7: Writing the command register with bit 1 set makes every enabled channel take its current synchronised input at that clock edge.
- R8: The prescaler produces a one-cycle tick once every `TICK_DIV` clocks.
- R9: An enabled channel takes a new level only after its synchronised input has differed from the output on N+1 consecutive ticks, where N is the active interval. A shorter excursion is rejected.
- R10: With an active interval of zero, an enabled channel follows its input on the first tick after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | CH | Raw asynchronous input lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback byte of filtered levels, combinational on address |

## Verification
Readback is combinational on the address, so every result appears at the port as soon as the registers update. A pass-through channel is due two edges after its input changes. An enabled channel changes no earlier than N·TICK_DIV+3 edges after the input changes and no later than (N+2)·TICK_DIV+2 edges after it. The bench therefore checks "not yet" before the lower bound and "done" after the upper bound, so the prescaler phase does not matter. Command effects are due on the edge that performs the write. The bench samples all three bytes within one low clock phase, so no clock edge falls between the byte reads.

// File: rtl/deglitch_bank.sv
module deglitch_bank #(
  parameter int CH       = 24,
  parameter int TICK_DIV = 20,
  parameter int IVW      = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] din,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata
);
  localparam int NB = CH / 8;
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [3:0] A_IVL = 4'h4;
  localparam logic [3:0] A_ENA = 4'h8;
  localparam logic [3:0] A_CMD = 4'hC;

  logic [CH-1:0]  sync1, sync2, filt, en, level;
  logic [IVW-1:0] ival_stage, ival_act;
  logic [PW-1:0]  pre;
  logic           tick;

  wire cmd_hit  = reg_we && reg_addr == A_CMD;
  wire clr_filt = cmd_hit && reg_wdata[1];
  wire restart  = cmd_hit && reg_wdata[0];

  assign tick  = pre == PW'(TICK_DIV - 1);
  assign level = (filt & en) | (sync2 & ~en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else if (restart || tick) pre <= '0;
    else pre <= pre + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ival_stage <= '0;
      ival_act   <= '0;
      en         <= '0;
    end else begin
      for (int k = 0; k < 3; k++)
        if (reg_we && reg_addr == A_IVL + 4'(k))
          for (int b = 0; b < 8; b++)
            if (8*k + b < IVW) ival_stage[8*k+b] <= reg_wdata[b];
      for (int k = 0; k < NB; k++)
        if (reg_we && reg_addr == A_ENA + 4'(k))
          en[8*k +: 8] <= reg_wdata;
      if (restart) ival_act <= ival_stage;
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [IVW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        filt[i] <= 1'b0;
        cnt     <= '0;
      end else if (clr_filt || !en[i]) begin
        filt[i] <= sync2[i];
        cnt     <= '0;
      end else if (restart || sync2[i] == filt[i]) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt >= ival_act) begin
          filt[i] <= sync2[i];
          cnt     <= '0;
        end else begin
          cnt <= cnt + IVW'(1);
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NB; k++)
      if (reg_addr == 4'(k)) reg_rdata = level[8*k +: 8];
  end
endmodule

// File: rtl/deglitch_bank_chk.sv
module deglitch_bank_chk #(
  parameter int CH  = 24,
  parameter int IVW = 20,
  parameter int PW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           clr_filt,
  input logic           restart,
  input logic [PW-1:0]  pre,
  input logic [CH-1:0]  en,
  input logic [CH-1:0]  filt,
  input logic [CH-1:0]  sync2,
  input logic [IVW-1:0] ival_stage,
  input logic [IVW-1:0] ival_act
);
  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ival_act == $past(ival_stage)) && (pre == '0));

  // R7
  clear_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_filt |=> ((filt ^ $past(sync2)) & $past(en)) == '0);

  // R9
  change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((filt ^ $past(filt)) & $past(en)) != '0) |-> ($past(tick) || $past(clr_filt)));

  // R2
  reset_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> en == '0);
endmodule

bind deglitch_bank deglitch_bank_chk #(.CH(CH), .IVW(IVW), .PW(PW)) chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .clr_filt(clr_filt), .restart(restart),
  .pre(pre), .en(en), .filt(filt), .sync2(sync2),
  .ival_stage(ival_stage), .ival_act(ival_act)
);

// File: tb/deglitch_bank_test.sv
module deglitch_bank_test;
  localparam int CH = 24;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CH-1:0] din = '0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  deglitch_bank #(.CH(CH), .TICK_DIV(DIV), .IVW(20)) uut (
    .clk(clk), .rst_n(rst_n), .din(din), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #5 clk = ~clk;

  // {din, hold cycles, expected readback}; low 12 channels filtered, interval 2 (R9, R1)
  localparam logic [55:0] VEC [7] = '{
    {24'hFFFFFF, 8'd3,  24'hFFF000},
    {24'hFFFFFF, 8'd30, 24'hFFFFFF},
    {24'h000000, 8'd3,  24'h000FFF},
    {24'h000000, 8'd30, 24'h000000},
    {24'hA5A5A5, 8'd30, 24'hA5A5A5},
    {24'h5A5A5A, 8'd2,  24'h5A55A5},
    {24'h5A5A5A, 8'd30, 24'h5A5A5A}
  };

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd3(output logic [23:0] v);
    for (int k = 0; k < 3; k++) begin
      reg_addr = 4'(k);
      #1 v[8*k +: 8] = reg_rdata;
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    din = 24'h123456;
    waitc(3);
    rst_n = 1'b1;
    waitc(3);
    rd3(v); chk("R2 reset pass-through", v, 24'h123456);
    din = 24'h000000;
    waitc(2);
    rd3(v); chk("R1 two-edge latency", v, 24'h000000);

    wr(4'h8, 8'hFF); wr(4'h9, 8'h0F); wr(4'hA, 8'h00);
    wr(4'h4, 8'h02); wr(4'h5, 8'h00); wr(4'h6, 8'h00); wr(4'hC, 8'h01);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      din = VEC[i][55:32];
      waitc(int'(VEC[i][31:24]));
      rd3(v); chk($sformatf("R9/R4 vector %0d", i), v, VEC[i][23:0]);
    end

    // R10 / R8: interval zero, follow within one tick period
    wr(4'h4, 8'h00); wr(4'h5, 8'h00); wr(4'h6, 8'h00); wr(4'hC, 8'h01);
    din = 24'hA5A5A5;
    waitc(10);
    rd3(v); chk("R10 zero interval", v, 24'hA5A5A5);

    // R6: staged value alone has no effect
    wr(4'h4, 8'hE8); wr(4'h5, 8'h03);
    din = 24'hFFFFFF;
    waitc(10);
    rd3(v); chk("R6 staged not active", v, 24'hFFFFFF);
    wr(4'hC, 8'h01);
    din = 24'h000000;
    waitc(30);
    rd3(v); chk("R6 restart loads interval", v, 24'h000FFF);

    // R7: filter reset snaps outputs
    wr(4'hC, 8'h02);
    rd3(v); chk("R7 clear filter state", v, 24'h000000);

    // R5: upper nibble of third interval byte ignored
    wr(4'h4, 8'h00); wr(4'h5, 8'h00); wr(4'h6, 8'hF0); wr(4'hC, 8'h01);
    din = 24'hFFFFFF;
    waitc(10);
    rd3(v); chk("R5 nibble ignored", v, 24'hFFFFFF);

    // R3: unmapped address reads zero
    reg_addr = 4'h3;
    #1 chk("R3 unmapped read", {16'h0, reg_rdata}, 24'h000000);

    // R4: only channel 23 filtered
    wr(4'h8, 8'h00); wr(4'h9, 8'h00); wr(4'hA, 8'h80);
    wr(4'h4, 8'hE8); wr(4'h5, 8'h03); wr(4'h6, 8'h00); wr(4'hC, 8'h01);
    din = 24'h000000;
    waitc(10);
    rd3(v); chk("R4 byte lane enable", v, 24'h800000);

    // R9 / R8: interval 3 timing window
    wr(4'h8, 8'hFF); wr(4'h9, 8'hFF); wr(4'hA, 8'hFF);
    wr(4'h4, 8'h03); wr(4'h5, 8'h00); wr(4'h6, 8'h00); wr(4'hC, 8'h03);
    rd3(v); chk("R7 clear with all enabled", v, 24'h000000);
    din = 24'h000001;
    waitc(12);
    rd3(v); chk("R9 not before window", v, 24'h000000);
    waitc(20);
    rd3(v); chk("R9 after window", v, 24'h000001);

    // R9: short pulse rejected
    din = 24'h000000;
    waitc(6);
    din = 24'h000001;
    waitc(40);
    rd3(v); chk("R9 glitch rejected", v, 24'h000001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule